// File: doc/BRIEF.md
# Gated Down-Counter Timer Channel

A single 16-bit timer channel. It counts down once for each count-enable strobe that arrives while its gate is high. A host loads a start value together with a mode code and a binary/decimal flag. From then on, the channel runs by itself. It shapes a waveform on `out_o`, shows the live count on `count_o`, and raises `tc_o` for one system clock at each terminal event. That pulse can drive an interrupt line directly. The channel keeps no pending state: each event is simply another pulse.

There are three behaviours. The one-shot mode raises the output once the loaded count has run out. The rate generator drops the output for one count step per period and reloads by itself. The square-wave divider splits each period into a high part and a low part. A start value of zero stands for the largest count the chosen number system allows. Decimal operation keeps every nibble of the count as a digit from 0 to 9.

Top module: `dcnt_timer`

## Requirements
- R1: While reset is held, and after it until the first load, `count_o` is 0, `out_o` is 0 and `tc_o` is 0; count strobes have no effect before the first load.
- R2: A cycle with `load_i` high makes `count_o` equal `load_val_i` on the next cycle and latches `mode_i` and `bcd_i`; a count strobe in that same cycle is ignored.
- R3: A count step happens only in a cycle with `tick_i` and `gate_i` both high; otherwise `count_o` holds its value.
- R4: With `bcd_i` = 0 each step subtracts one, and 0x0000 steps to 0xFFFF; a loaded 0 in one-shot mode reaches 0 again after exactly 65536 steps.
- R5: With `bcd_i` = 1 the four nibbles are decimal digits and each step subtracts one in decimal, so 0x0010 steps to 0x0009 and 0x0000 steps to 0x9999; a loaded 0 spans 10000 steps.
- R6: Mode code 2'b00 (one-shot): `out_o` is 0 in the cycle after a load, including a reload in the middle of a count. It becomes 1 with the step that takes the count from 1 to 0. It then stays 1 until the next load, while the count keeps wrapping.
- R7: Mode codes 2'b01 and 2'b11 (rate generator): `out_o` is 0 exactly while the count is 1. The step taken at count 1 reloads the start value, so the period is N steps.
- R8: Mode code 2'b10 (square wave): `out_o` starts at 1 after a load and the count reloads at 1 as in R7. Of each N-step period, the output is high for the first ceil(N/2) steps and low for the last floor(N/2).
- R9: `tc_o` is high for one clock, in the cycle after a qualifying step. In one-shot mode this is only the first step from 1 to 0 after a load. In the periodic modes it is every reload step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gate_i | input | 1 | Counting is allowed while high |
| tick_i | input | 1 | Count-enable strobe, one step per clock it is high |
| load_i | input | 1 | Load strobe for start value, mode and number system |
| load_val_i | input | 16 | Start value; 0 means the maximum count |
| mode_i | input | 2 | 00 one-shot, 01 rate, 10 square wave, 11 rate |
| bcd_i | input | 1 | 1 selects decimal counting |
| out_o | output | 1 | Mode-dependent output waveform |
| count_o | output | 16 | Live count |
| tc_o | output | 1 | One-clock terminal-count pulse |

## Verification
Some properties are checked by assertions on every cycle. The count holds when no step occurs and takes the load value after a load. `tc_o` is checked to follow a step. The one-shot output is checked to stay high once raised. In the rate modes, the output is checked against count == 1. In the square mode, the output is checked against the half-period threshold. Other behaviour can only be shown by the bench's scenarios:
- that full periods have the right lengths;
- that the odd-N split is right;
- the decimal borrow chain;
- the 65536- and 10000-step spans of a zero load;
- that a count strobe is ignored in a load cycle.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic [1:0] {
    MODE_TERM     = 2'b00,
    MODE_RATE     = 2'b01,
    MODE_SQUARE   = 2'b10,
    MODE_RATE_ALT = 2'b11
  } dcnt_mode_e;
endpackage

// File: rtl/dcnt_dec.sv
// Subtract one, in binary or in packed decimal digits.
module dcnt_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         bcd_i,
  output logic [W-1:0] dec_o
);
  localparam int ND = W / 4;

  logic [W-1:0] bin_dec;
  logic [W-1:0] bcd_dec;
  logic [ND:0]  borrow;

  assign bin_dec   = val_i - W'(1);
  assign borrow[0] = 1'b1;

  for (genvar i = 0; i < ND; i++) begin : g_digit
    logic [3:0] dig;
    assign dig = val_i[4*i +: 4];
    always_comb begin
      if (!borrow[i]) begin
        bcd_dec[4*i +: 4] = dig;
      end else if (dig == 4'd0) begin
        bcd_dec[4*i +: 4] = 4'd9;
      end else begin
        bcd_dec[4*i +: 4] = dig - 4'd1;
      end
    end
    assign borrow[i+1] = borrow[i] & (dig == 4'd0);
  end

  assign dec_o = bcd_i ? bcd_dec : bin_dec;
endmodule

// File: rtl/dcnt_half.sv
// Square-wave threshold: floor(N/2), where a stored 0 stands for the maximum N.
module dcnt_half #(
  parameter int W = 16
) (
  input  logic [W-1:0] rld_i,
  input  logic         bcd_i,
  output logic [W-1:0] half_o
);
  localparam int ND = W / 4;

  logic         is_max;
  logic [W-1:0] bin_half;
  logic [W-1:0] bcd_half;
  logic [ND:0]  odd_above;

  assign is_max        = (rld_i == '0);
  assign bin_half      = {is_max, rld_i[W-1:1]};
  assign odd_above[ND] = is_max;

  for (genvar i = 0; i < ND; i++) begin : g_digit
    logic [3:0] dig;
    assign dig = rld_i[4*i +: 4];
    assign bcd_half[4*i +: 4] = {1'b0, dig[3:1]} + (odd_above[i+1] ? 4'd5 : 4'd0);
    assign odd_above[i] = dig[0];
  end

  assign half_o = bcd_i ? bcd_half : bin_half;
endmodule

// File: rtl/dcnt_core.sv
module dcnt_core
  import dcnt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         gate_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  dcnt_mode_e   load_mode_i,
  input  logic         load_bcd_i,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output dcnt_mode_e   mode_q,
  output logic         bcd_q,
  output logic         armed_q,
  output logic         step_o,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] dec_val;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  dcnt_dec #(.W(W)) u_dec (
    .val_i (cnt_q),
    .bcd_i (bcd_q),
    .dec_o (dec_val)
  );

  always_comb begin
    step_o = armed_q & tick_i & gate_i & ~load_i;
    if ((mode_q != MODE_TERM) && (cnt_q == ONE)) begin
      nxt_o = rld_q;
    end else begin
      nxt_o = dec_val;
    end
    cnt_d  = load_i ? load_val_i : nxt_o;
    cnt_en = load_i | step_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rld_q   <= '0;
      mode_q  <= MODE_TERM;
      bcd_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      if (load_i) begin
        rld_q   <= load_val_i;
        mode_q  <= load_mode_i;
        bcd_q   <= load_bcd_i;
        armed_q <= 1'b1;
      end
    end
  end

  AST_IDLE_BEFORE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> cnt_q == '0); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)); // R2
  AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(tick_i && gate_i)) |=> $stable(cnt_q)); // R3
  AST_BIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !bcd_q && mode_q == MODE_TERM) |=> cnt_q == $past(cnt_q) - W'(1)); // R4
endmodule

// File: rtl/dcnt_wave.sv
module dcnt_wave
  import dcnt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  dcnt_mode_e   load_mode_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         armed_i,
  input  dcnt_mode_e   mode_i,
  input  logic         bcd_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] rld_i,
  input  logic [W-1:0] nxt_i,
  output logic         out_q,
  output logic         tc_q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] half;
  logic         out_d;
  logic         tc_d;
  logic         out_en;

  dcnt_half #(.W(W)) u_half (
    .rld_i  (rld_i),
    .bcd_i  (bcd_i),
    .half_o (half)
  );

  always_comb begin
    out_d  = out_q;
    tc_d   = 1'b0;
    out_en = load_i | step_i;
    if (load_i) begin
      case (load_mode_i)
        MODE_TERM:   out_d = 1'b0;
        MODE_SQUARE: out_d = 1'b1;
        default:     out_d = (load_val_i != ONE);
      endcase
    end else if (step_i) begin
      case (mode_i)
        MODE_TERM: begin
          if ((cnt_i == ONE) && !out_q) begin
            out_d = 1'b1;
            tc_d  = 1'b1;
          end
        end
        MODE_SQUARE: begin
          out_d = (nxt_i == '0) || (nxt_i > half);
          tc_d  = (cnt_i == ONE);
        end
        default: begin
          out_d = (nxt_i != ONE);
          tc_d  = (cnt_i == ONE);
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= tc_d;
      if (out_en) begin
        out_q <= out_d;
      end
    end
  end

  AST_TC_FOLLOWS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q |-> $past(step_i)); // R9
  AST_TERM_OUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TERM && out_q && !load_i) |=> out_q); // R6
  AST_TERM_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TERM && step_i && cnt_i == ONE) |=> out_q); // R6
  AST_RATE_LOW_AT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && (mode_i == MODE_RATE || mode_i == MODE_RATE_ALT)) |-> out_q == (cnt_i != ONE)); // R7
  AST_SQUARE_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && mode_i == MODE_SQUARE) |-> out_q == ((cnt_i == '0) || (cnt_i > half))); // R8
endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer
  import dcnt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_i,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [1:0]    mode_i,
  input  logic          bcd_i,
  output logic          out_o,
  output logic [CW-1:0] count_o,
  output logic          tc_o
);
  logic [1:0]    rst_sync;
  logic          rst_n;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] rld_q;
  logic [CW-1:0] nxt;
  dcnt_mode_e    mode_q;
  dcnt_mode_e    load_mode;
  logic          bcd_q;
  logic          armed_q;
  logic          step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n     = rst_sync[1];
  assign load_mode = dcnt_mode_e'(mode_i);

  dcnt_core #(.W(CW)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .tick_i      (tick_i),
    .gate_i      (gate_i),
    .load_i      (load_i),
    .load_val_i  (load_val_i),
    .load_mode_i (load_mode),
    .load_bcd_i  (bcd_i),
    .cnt_q       (cnt_q),
    .rld_q       (rld_q),
    .mode_q      (mode_q),
    .bcd_q       (bcd_q),
    .armed_q     (armed_q),
    .step_o      (step),
    .nxt_o       (nxt)
  );

  dcnt_wave #(.W(CW)) u_wave (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .load_i      (load_i),
    .load_mode_i (load_mode),
    .load_val_i  (load_val_i),
    .step_i      (step),
    .armed_i     (armed_q),
    .mode_i      (mode_q),
    .bcd_i       (bcd_q),
    .cnt_i       (cnt_q),
    .rld_i       (rld_q),
    .nxt_i       (nxt),
    .out_q       (out_o),
    .tc_q        (tc_o)
  );

  assign count_o = cnt_q;
endmodule

// File: tb/dcnt_timer_test.sv
`timescale 1ns/1ps
module dcnt_timer_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        gate_i, tick_i, load_i, bcd_i;
  logic [15:0] load_val_i;
  logic [1:0]  mode_i;
  logic        out_o, tc_o;
  logic [15:0] count_o;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [15:0] c;
    logic        o;
    logic        t;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference model state
  int m_rng, m_n, m_rem, m_mode;
  bit m_bcd, m_arm, m_out, m_tc;

  always #2.5 clk = ~clk;

  dcnt_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .gate_i(gate_i), .tick_i(tick_i),
    .load_i(load_i), .load_val_i(load_val_i), .mode_i(mode_i), .bcd_i(bcd_i),
    .out_o(out_o), .count_o(count_o), .tc_o(tc_o)
  );

  function automatic int b2i(logic [15:0] v);
    return int'(v[15:12]) * 1000 + int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [15:0] i2b(int x);
    return {4'(x / 1000 % 10), 4'(x / 100 % 10), 4'(x / 10 % 10), 4'(x % 10)};
  endfunction

  task automatic drv(input bit tk, input bit gt, input bit ld, input logic [15:0] v,
                     input logic [1:0] md, input bit bc, input string tag);
    exp_t e;
    @(negedge clk);
    tick_i = tk; gate_i = gt; load_i = ld; load_val_i = v; mode_i = md; bcd_i = bc;
    m_tc = 1'b0;
    if (ld) begin
      m_rng  = bc ? 10000 : 65536;
      m_n    = (v == 16'd0) ? m_rng : (bc ? b2i(v) : int'(v));
      m_mode = int'(md);
      m_bcd  = bc;
      m_arm  = 1'b1;
      if (md == 2'b00) begin
        m_rem = m_n % m_rng;
        m_out = 1'b0;
      end else begin
        m_rem = m_n;
        m_out = (md == 2'b10) ? 1'b1 : (m_n != 1);
      end
    end else if (tk && gt && m_arm) begin
      if (m_mode == 0) begin
        if (m_rem == 1 && !m_out) begin
          m_out = 1'b1;
          m_tc  = 1'b1;
        end
        m_rem = (m_rem + m_rng - 1) % m_rng;
      end else begin
        if (m_rem == 1) begin
          m_rem = m_n;
          m_tc  = 1'b1;
        end else begin
          m_rem = m_rem - 1;
        end
        m_out = (m_mode == 2) ? (m_rem > m_n / 2) : (m_rem != 1);
      end
    end
    e.c   = m_arm ? (m_bcd ? i2b(m_rem % m_rng) : 16'(m_rem % m_rng)) : 16'd0;
    e.o   = m_arm ? m_out : 1'b0;
    e.t   = m_tc;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic run(input int n, input bit tk, input bit gt, input string tag);
    for (int i = 0; i < n; i++) drv(tk, gt, 1'b0, 16'h0, 2'b00, 1'b0, tag);
  endtask

  task automatic ld(input logic [15:0] v, input logic [1:0] md, input bit bc,
                    input bit tk, input string tag);
    drv(tk, 1'b1, 1'b1, v, md, bc, tag);
  endtask

  // monitor: pop expected items and compare after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        e = sb.pop_front();
        total++;
        if (count_o !== e.c || out_o !== e.o || tc_o !== e.t) begin
          bad++;
          $display("FAIL %s count=%h/%h out=%b/%b tc=%b/%b (actual/expected) t=%0t",
                   e.tag, count_o, e.c, out_o, e.o, tc_o, e.t, $time);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_arm = 1'b0; m_rem = 0; m_rng = 65536; m_n = 0; m_mode = 0;
    m_bcd = 1'b0; m_out = 1'b0; m_tc = 1'b0;
    rst_ni = 1'b0; gate_i = 1'b1; tick_i = 1'b1; load_i = 1'b0;
    load_val_i = 16'h0; mode_i = 2'b00; bcd_i = 1'b0;
    repeat (3) @(negedge clk);
    total++; // R1 reset state
    if (count_o !== 16'h0 || out_o !== 1'b0 || tc_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset count=%h/0000 out=%b/0 tc=%b/0 (actual/expected)",
               count_o, out_o, tc_o);
    end
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    run(4, 1'b1, 1'b1, "R1 strobes before load");

    // one-shot, binary, start 5, gate pattern
    ld(16'd5, 2'b00, 1'b0, 1'b1, "R2 load beats strobe");
    for (int i = 0; i < 6; i++) begin
      drv(1'b1, 1'b0, 1'b0, 16'h0, 2'b00, 1'b0, "R3 gate low holds");
      drv(1'b0, 1'b1, 1'b0, 16'h0, 2'b00, 1'b0, "R3 no strobe holds");
      drv(1'b1, 1'b1, 1'b0, 16'h0, 2'b00, 1'b0, "R6 one-shot step");
    end
    run(3, 1'b1, 1'b1, "R9 one-shot no repeat tc");
    ld(16'd3, 2'b00, 1'b0, 1'b0, "R6 reload drives low");
    run(2, 1'b1, 1'b1, "R6 partial count");
    ld(16'd10, 2'b00, 1'b0, 1'b1, "R6 restart mid count");
    run(12, 1'b1, 1'b1, "R6 reach zero");

    // rate generator
    ld(16'd4, 2'b01, 1'b0, 1'b0, "R7 rate load");
    run(9, 1'b1, 1'b1, "R7 rate period");
    run(8, 1'b1, 1'b1, "R9 rate tc");
    ld(16'd3, 2'b11, 1'b0, 1'b0, "R7 alt code load");
    run(7, 1'b1, 1'b1, "R7 alt code");
    for (int i = 0; i < 6; i++) begin
      drv(1'b1, 1'b1, 1'b0, 16'h0, 2'b00, 1'b0, "R7 sparse strobes");
      drv(1'b0, 1'b1, 1'b0, 16'h0, 2'b00, 1'b0, "R3 idle between strobes");
    end

    // square wave
    ld(16'd5, 2'b10, 1'b0, 1'b0, "R8 odd load");
    run(12, 1'b1, 1'b1, "R8 odd split");
    ld(16'd4, 2'b10, 1'b0, 1'b0, "R8 even load");
    run(10, 1'b1, 1'b1, "R8 even split");
    ld(16'd2, 2'b10, 1'b0, 1'b0, "R8 n2 load");
    run(6, 1'b1, 1'b1, "R8 n2");
    ld(16'd3, 2'b10, 1'b0, 1'b0, "R8 n3 load");
    for (int i = 0; i < 8; i++) begin
      drv(1'b1, 1'b1, 1'b0, 16'h0, 2'b00, 1'b0, "R8 gated split");
      drv(1'b1, 1'b0, 1'b0, 16'h0, 2'b00, 1'b0, "R3 gate low square");
    end

    // decimal
    ld(16'h0012, 2'b01, 1'b1, 1'b0, "R5 decimal rate load");
    run(30, 1'b1, 1'b1, "R5 decimal borrow");
    ld(16'h0007, 2'b10, 1'b1, 1'b0, "R5 decimal square load");
    run(16, 1'b1, 1'b1, "R5 decimal square");
    ld(16'h0000, 2'b00, 1'b1, 1'b0, "R5 decimal max load");
    run(10001, 1'b1, 1'b1, "R5 decimal max span");

    // binary maximum
    ld(16'h0000, 2'b00, 1'b0, 1'b0, "R4 binary max load");
    run(65537, 1'b1, 1'b1, "R4 binary max span");

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule